// File: doc/BRIEF.md
# DSP-Frame Audio Serial Transmitter

This block turns a pair of parallel audio samples, one for the left channel and one for the right, into a serial stream on one data line. The stream follows a DSP-style frame. A rising frame-sync marks the start of a frame. The left word's most significant bit is driven in the same bit-clock period as that rise. The right word follows the left word's last bit with no gap. After the right word's last bit the line stays low until the next frame starts.

The block runs entirely on a fast system clock. The bit clock and the frame sync arrive as plain inputs, and each passes through a synchronizer. A falling bit-clock edge is detected inside the block, and every change of the data line is made in response to one. A receiver can therefore sample the line on the rising bit-clock edge.

At each frame start the block captures three things: the two sample words, a 2-bit word-length selector and a valid strobe. A sample occupies bits [n-1:0] of its input word. Any change to these inputs later in the frame has no effect on the frame being sent. If the frame-sync rises again before both words are complete, the frame in progress is dropped and the new frame starts at once.

Top module: `dsp_ser_tx`

## Requirements
- R1: After reset, and before any frame start, `sdata` is 0.
- R2: The left word's bit n-1 is on `sdata` in the bit period that begins at the falling bit-clock edge where `fsync_in` is first seen high. This holds provided `word_valid` is high at that edge.
- R3: `sdata` changes only in the system-clock cycle that follows a detected falling edge of `bclk_in`. The delay from the pin to `sdata` is three system-clock cycles.
- R4: Each word is sent most significant bit first, n bits per word, with the left word first. The right word's bit n-1 comes in the bit period right after the left word's bit 0.
- R5: The word length n is set by `wlen_sel`: 00 gives 16, 01 gives 20, 10 gives 24 and 11 gives 32. The selector is sampled only at frame start.
- R6: From the bit period after the right word's bit 0 until the next frame start, `sdata` is 0.
- R7: `left_word`, `right_word` and `wlen_sel` are captured at frame start. Changes to them during the frame do not alter the bits sent.
- R8: If `word_valid` is low at a frame start, `sdata` stays 0 for that entire frame.
- R9: A frame-sync rise that arrives before the current frame is complete drops the remaining bits. The new left word's bit n-1 goes out in that same bit period.
- R10: Only a low-to-high change of `fsync_in` between two successive falling bit-clock edges starts a frame. Holding `fsync_in` high does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Bit clock, asynchronous to `clk` |
| fsync_in | input | 1 | Frame sync; its rise marks a frame start |
| wlen_sel | input | 2 | Word-length selector (00:16, 01:20, 10:24, 11:32) |
| word_valid | input | 1 | Samples valid, taken at frame start |
| left_word | input | MAX_W | Left-channel sample in bits [n-1:0] |
| right_word | input | MAX_W | Right-channel sample in bits [n-1:0] |
| sdata | output | 1 | Serial data output |

## Verification
The hardest case to reach from the ports is a frame start that lands on a shifter that is still busy. The bench builds it by cutting frames short: it raises the frame sync a few bit periods after the left word has finished, while right-word bits are still being sent. It then checks that the next bit period already carries the new left word's most significant bit. A second hard case is a frame sync held high across a whole frame, which must not restart the frame. The bench keeps `fsync_in` high for nearly every bit period of one frame and compares each bit against a single, uninterrupted frame.

// File: rtl/dsp_tx_pkg.sv
package dsp_tx_pkg;

  typedef enum logic [1:0] {
    WL16 = 2'b00,
    WL20 = 2'b01,
    WL24 = 2'b10,
    WL32 = 2'b11
  } wlen_e;

  // Number of bits per channel word for a selector value.
  function automatic int unsigned word_bits(input logic [1:0] sel);
    case (wlen_e'(sel))
      WL16:    return 16;
      WL20:    return 20;
      WL24:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/dsp_tx_sync.sv
module dsp_tx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dsp_tx_shifter.sv
module dsp_tx_shifter #(
  parameter int MAX_W = 32,
  localparam int SHW  = 2 * MAX_W,
  localparam int CNTW = $clog2(SHW),
  localparam int NW   = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_ev,
  input  logic             frame_start,
  input  logic             load_valid,
  input  logic [NW-1:0]    word_n,
  input  logic [MAX_W-1:0] left_word,
  input  logic [MAX_W-1:0] right_word,
  output logic             sdata,
  output logic             active,
  output logic [CNTW-1:0]  bits_left
);
  // Place the left word's n bits at the top and the right word's n bits
  // right below them, so that the whole frame leaves MSB first.
  function automatic logic [SHW-1:0] pack_words(input logic [MAX_W-1:0] l,
                                                input logic [MAX_W-1:0] r,
                                                input int unsigned n);
    logic [SHW-1:0] mask;
    logic [SHW-1:0] lw;
    logic [SHW-1:0] rw;
    mask = (SHW'(1) << n) - SHW'(1);
    lw   = SHW'(l) & mask;
    rw   = SHW'(r) & mask;
    return (lw << (SHW - n)) | (rw << (SHW - 2 * n));
  endfunction

  logic [SHW-1:0] shreg;
  logic [SHW-1:0] frame_bits;
  logic           more_bits;

  assign frame_bits = pack_words(left_word, right_word, int'(word_n));
  assign more_bits  = active && (bits_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      sdata     <= 1'b0;
      active    <= 1'b0;
      bits_left <= '0;
    end else if (frame_start) begin
      if (load_valid) begin
        sdata     <= frame_bits[SHW-1];
        shreg     <= frame_bits << 1;
        bits_left <= CNTW'(2 * int'(word_n) - 1);
        active    <= 1'b1;
      end else begin
        sdata     <= 1'b0;
        shreg     <= '0;
        bits_left <= '0;
        active    <= 1'b0;
      end
    end else if (fall_ev) begin
      if (more_bits) begin
        sdata     <= shreg[SHW-1];
        shreg     <= shreg << 1;
        bits_left <= bits_left - CNTW'(1);
      end else begin
        sdata  <= 1'b0;
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsp_ser_tx.sv
module dsp_ser_tx #(
  parameter int MAX_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_in,
  input  logic             fsync_in,
  input  logic [1:0]       wlen_sel,
  input  logic             word_valid,
  input  logic [MAX_W-1:0] left_word,
  input  logic [MAX_W-1:0] right_word,
  output logic             sdata
);
  localparam int CNT_W = $clog2(2 * MAX_W);
  localparam int NW    = $clog2(MAX_W + 1);

  logic bclk_lvl, fsync_lvl;
  logic bclk_prev, fs_at_fall;
  logic fall_ev, frame_start;
  logic active;
  logic [CNT_W-1:0] bits_left;
  logic [NW-1:0] word_n;

  dsp_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bclk_sync (
    .clk(clk), .rst_n(rst_n), .d(bclk_in), .q(bclk_lvl));

  dsp_tx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_fsync_sync (
    .clk(clk), .rst_n(rst_n), .d(fsync_in), .q(fsync_lvl));

  // fs_at_fall resets high so that a frame sync already high when reset
  // is released does not count as a rise.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_prev  <= 1'b1;
      fs_at_fall <= 1'b1;
    end else begin
      bclk_prev <= bclk_lvl;
      if (fall_ev) fs_at_fall <= fsync_lvl;
    end
  end

  assign fall_ev     = bclk_prev & ~bclk_lvl;
  assign frame_start = fall_ev & fsync_lvl & ~fs_at_fall;

  always_comb begin
    int unsigned n;
    n = dsp_tx_pkg::word_bits(wlen_sel);
    if (n > MAX_W) n = MAX_W;
    word_n = NW'(n);
  end

  dsp_tx_shifter #(.MAX_W(MAX_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .frame_start(frame_start),
    .load_valid(word_valid), .word_n(word_n), .left_word(left_word),
    .right_word(right_word), .sdata(sdata), .active(active),
    .bits_left(bits_left));
endmodule

// File: rtl/dsp_ser_tx_chk.sv
module dsp_ser_tx_chk #(
  parameter int MAX_W = 32,
  parameter int CNTW  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_ev,
  input logic             frame_start,
  input logic             word_valid,
  input logic [1:0]       wlen_sel,
  input logic [MAX_W-1:0] left_word,
  input logic             sdata,
  input logic             active,
  input logic [CNTW-1:0]  bits_left
);
  logic exp_msb;
  always_comb begin
    int unsigned n;
    n = dsp_tx_pkg::word_bits(wlen_sel);
    if (n > MAX_W) n = MAX_W;
    exp_msb = left_word[n-1];
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sdata && !active));

  a_r2_left_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && word_valid) |=> (sdata == $past(exp_msb)));

  a_r3_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> $past(fall_ev));

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && !frame_start && active && bits_left != '0)
      |=> (bits_left == $past(bits_left) - CNTW'(1)));

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdata);

  a_r8_invalid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !word_valid) |=> !active);
endmodule

bind dsp_ser_tx dsp_ser_tx_chk #(.MAX_W(MAX_W), .CNTW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .frame_start(frame_start),
  .word_valid(word_valid), .wlen_sel(wlen_sel), .left_word(left_word),
  .sdata(sdata), .active(active), .bits_left(bits_left));

// File: tb/dsp_ser_tx_bench.sv
`timescale 1ns/1ps
module dsp_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_in = 1'b1;
  logic        fsync_in = 1'b0;
  logic [1:0]  wlen_sel = 2'b00;
  logic        word_valid = 1'b0;
  logic [31:0] left_word = '0;
  logic [31:0] right_word = '0;
  logic        sdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dsp_ser_tx u_dsp_ser_tx (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
    .wlen_sel(wlen_sel), .word_valid(word_valid), .left_word(left_word),
    .right_word(right_word), .sdata(sdata));

  function automatic int sel_bits(input logic [1:0] s);
    return 16 + 4 * int'(s) + ((s == 2'b11) ? 4 : 0);
  endfunction

  // Bit k of a frame counted from the frame-start falling edge.
  function automatic logic exp_bit(input logic [31:0] l, input logic [31:0] r,
                                   input int n, input bit v, input int k);
    if (!v) return 1'b0;
    if (k < n) return l[n-1-k];
    if (k < 2 * n) return r[2*n-1-k];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: sdata=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // One frame of 'total' bit periods. Output sampled 4 clocks after each
  // falling bit edge (design latency is 3 clocks).
  task automatic run_frame(input logic [31:0] l, input logic [31:0] r,
                           input logic [1:0] sel, input bit v, input int total,
                           input bit hold, input int change_at, input string req);
    int n;
    n = sel_bits(sel);
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      bclk_in  = 1'b0;
      fsync_in = (k == 0) || (hold && k < total - 1);
      if (k == 0) begin
        left_word = l; right_word = r; wlen_sel = sel; word_valid = v;
      end
      if (k == change_at) begin
        left_word = ~l; right_word = ~r; wlen_sel = sel + 2'd1; word_valid = ~v;
      end
      repeat (3) @(negedge clk);
      @(negedge clk);
      begin
        logic e;
        string tag;
        e = exp_bit(l, r, n, v, k);
        if (k == 0 && v)      tag = {req, "/R2"};
        else if (k >= 2 * n)  tag = {req, "/R6"};
        else                  tag = {req, "/R4"};
        check(sdata === e, tag, sdata, e);
      end
      bclk_in = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, sdata=%0b expected %0b", sdata, 1'b0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sdata === 1'b0, "R1 reset idle", sdata, 1'b0);
    // Bit clock toggles with no frame: still idle (R1, R6).
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) bclk_in = 1'b0;
      repeat (4) @(negedge clk);
      check(sdata === 1'b0, "R1 no frame", sdata, 1'b0);
      bclk_in = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R5/R4 sweep: every word length under several patterns.
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] l, r;
        case (p)
          0: begin l = 32'hAAAA_AAAA; r = 32'h5555_5555; end
          1: begin l = 32'h8000_0001 | (32'h1 << (sel_bits(2'(s)) - 1)); r = 32'h0; end
          2: begin l = 32'h1 << (3 * s); r = 32'hFFFF_FFFF ^ (32'h1 << (5 + s)); end
          default: begin l = $urandom; r = $urandom; end
        endcase
        run_frame(l, r, 2'(s), 1'b1, 2 * sel_bits(2'(s)) + 3, 1'b0, -1, "R5");
      end
    end

    // R7: inputs (and selector) change mid-frame; frame uses captured values.
    run_frame(32'h1234_5678, 32'h9ABC_DEF0, 2'b01, 1'b1, 45, 1'b0, 3, "R7");
    run_frame(32'hDEAD_BEEF, 32'h0BAD_F00D, 2'b11, 1'b1, 68, 1'b0, 40, "R7");

    // R8: valid low at frame start, then a normal frame.
    run_frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, 1'b0, 52, 1'b0, -1, "R8");
    run_frame(32'hC3C3_C3C3, 32'h3C3C_3C3C, 2'b10, 1'b1, 50, 1'b0, -1, "R8");

    // R9: frames cut short while right word is being sent.
    run_frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 1'b1, 21, 1'b0, -1, "R9");
    run_frame(32'h0000_0000, 32'h0000_7FFF, 2'b00, 1'b1, 24, 1'b0, -1, "R9");
    run_frame(32'h00F0_0F0F, 32'h00A5_A5A5, 2'b10, 1'b1, 51, 1'b0, -1, "R9");

    // R10: frame sync held high for nearly the whole frame.
    run_frame(32'h0001_FFFE, 32'h0000_8001, 2'b00, 1'b1, 36, 1'b1, -1, "R10");
    run_frame(32'h0F0F_0, 32'h7_7777, 2'b01, 1'b1, 43, 1'b0, -1, "R10");

    // R3: pin-to-output latency is 3 clocks, nothing changes earlier.
    @(negedge clk);
    bclk_in = 1'b0; fsync_in = 1'b1;
    left_word = 32'h0000_8000; right_word = 32'h0; wlen_sel = 2'b00; word_valid = 1'b1;
    @(negedge clk); check(sdata === 1'b0, "R3 early", sdata, 1'b0);
    @(negedge clk); check(sdata === 1'b0, "R3 early", sdata, 1'b0);
    @(negedge clk); check(sdata === 1'b1, "R3 on time", sdata, 1'b1);
    repeat (2) @(negedge clk);
    bclk_in = 1'b1; fsync_in = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule